// File: doc/BRIEF.md
# Scanline and Vertical Blank Interrupt Unit

This unit turns raw video timing into two CPU interrupt sources. One source is the start of vertical blank. The other is a programmable line match. Each source latches a pending flag and has an enable bit. A single interrupt output is raised while any enabled source is pending.

The line match is evaluated only on the single-cycle pulse that marks the start of horizontal blank. It compares against the number of the line about to be drawn. In doubled-pixel modes (bitmap and tile) that line number is halved before the compare, because each logical line spans two display lines. In text mode the full line number is used. A match fires at most once per frame, and the one-shot is re-armed on the rising edge of vertical blank.

Software reaches three registers over a 16-bit request/acknowledge bus: a status word, an enable word and the line compare value. The status word shows the pending flags beside the live blank levels. Pending flags are cleared by writing ones to their bit positions in the status word.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset, all pending flags, enable bits and the compare value are zero, and both `irq` and `ack` are low.
- R2: A rising edge of `vblank` sets the vertical blank pending flag. Holding `vblank` high does not set the flag again once it has been cleared.
- R3: With `text_mode` low, a pulse on `hblank_start` sets the line pending flag when `line_next` shifted right by one equals the compare value. Without the pulse, nothing is set.
- R4: With `text_mode` high, the compare uses the full `line_next` value.
- R5: The line pending flag is set at most once between rising edges of `vblank`. A second display line that maps to the same logical line does not set it again. After the next rising edge of `vblank`, the same line can fire again.
- R6: The enable word (register 1) uses bit 0 for the vertical blank source and bit 1 for the line source. Bits 15:2 read back as zero. `irq` is high exactly while some pending flag has its enable bit set.
- R7: Reading the status word (register 0) returns: bit 0 = vertical blank pending, bit 1 = line pending, bit 4 = live `hblank`, bit 5 = live `vblank`. All other bits are zero.
- R8: Writing the status word clears each pending flag whose bit (0 or 1) is written as one. Flags written as zero are left unchanged.
- R9: When a set event and a clear of the same flag happen in the same cycle, the flag ends up set.
- R10: The compare register (register 2) holds 10 bits, and bits 15:10 read back as zero. Register 3 reads as zero and ignores writes.
- R11: A request seen while `ack` is low is carried out at that clock edge. `ack` is high for exactly the next cycle, and `rdata` is valid while `ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_next | input | 10 | Number of the upcoming display line |
| hblank | input | 1 | Live horizontal blank level |
| vblank | input | 1 | Live vertical blank level |
| hblank_start | input | 1 | One-cycle pulse at the start of horizontal blank |
| text_mode | input | 1 | 1 = full line compare (text), 0 = halved compare (bitmap/tile) |
| req | input | 1 | Bus request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register select: 0 status, 1 enable, 2 compare, 3 none |
| wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle acknowledge |
| rdata | output | 16 | Read data, valid with `ack` |
| irq | output | 1 | Combined interrupt request |

## Verification
A pending flag can be set by the timing side and cleared by a bus write in the same clock cycle. The bench provokes this collision for both sources. For the vertical blank source, it raises `vblank` on the same edge that accepts a write-one-to-clear. For the line source, it drives a matching `hblank_start` pulse on that same edge. A following status read must show the flag still set. The bench also places a second, halved-equal display line after a clear, to confirm that the one-shot keeps the flag clear until the next vertical blank.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_CMP  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int NUM_SRC   = 2;
  localparam int SRC_VBL   = 0;
  localparam int SRC_LINE  = 1;
  localparam int ST_HBLANK = 4;
  localparam int ST_VBLANK = 5;
endpackage

// File: rtl/sirq_line_match.sv
module sirq_line_match #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_next,
  input  logic              hblank_start,
  input  logic              text_mode,
  input  logic              vblank_rise,
  input  logic [LINE_W-1:0] cmp,
  output logic              fire
);
  // Logical line seen by software: halved in doubled-pixel modes.
  function automatic logic [LINE_W-1:0] logical_line(
    input logic [LINE_W-1:0] ln, input logic txt);
    return txt ? ln : (ln >> 1);
  endfunction

  logic done_q;

  assign fire = hblank_start && (logical_line(line_next, text_mode) == cmp) && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fire | (done_q & ~vblank_rise);
  end
endmodule

// File: rtl/sirq_pend_bank.sv
module sirq_pend_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= set[i] | (pend[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/sirq_regbus.sv
module sirq_regbus
  import scan_irq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               we,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               ack,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               hblank,
  input  logic               vblank,
  output logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] en,
  output logic [LINE_W-1:0]  cmp
);
  function automatic logic [DATA_W-1:0] status_word(
    input logic [NUM_SRC-1:0] p, input logic hb, input logic vb);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NUM_SRC-1:0] = p;
    w[ST_HBLANK]   = hb;
    w[ST_VBLANK]   = vb;
    return w;
  endfunction

  logic       accept;
  reg_sel_e   sel;
  logic [DATA_W-1:0] rd_mux;
  logic       wdata_unused;

  assign accept       = req && !ack;
  assign sel          = reg_sel_e'(addr);
  assign wdata_unused = ^wdata[DATA_W-1:LINE_W];
  assign clr          = (accept && we && sel == REG_STAT) ? wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    case (sel)
      REG_STAT: rd_mux = status_word(pend, hblank, vblank);
      REG_EN:   rd_mux = {{(DATA_W-NUM_SRC){1'b0}}, en};
      REG_CMP:  rd_mux = {{(DATA_W-LINE_W){1'b0}}, cmp};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
      en    <= '0;
      cmp   <= '0;
    end else begin
      ack <= accept;
      if (accept) begin
        rdata <= rd_mux;
        if (we && sel == REG_EN)  en  <= wdata[NUM_SRC-1:0];
        if (we && sel == REG_CMP) cmp <= wdata[LINE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import scan_irq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_next,
  input  logic              hblank,
  input  logic              vblank,
  input  logic              hblank_start,
  input  logic              text_mode,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic               vblank_q;
  logic               vbl_rise;
  logic               line_fire;
  logic [NUM_SRC-1:0] set_ev;
  logic [NUM_SRC-1:0] clr_ev;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] en_bits;
  logic [LINE_W-1:0]  cmp_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vblank_q <= 1'b0;
    else        vblank_q <= vblank;
  end

  assign vbl_rise = vblank && !vblank_q;

  sirq_line_match #(.LINE_W(LINE_W)) u_match (
    .clk(clk), .rst_n(rst_n), .line_next(line_next),
    .hblank_start(hblank_start), .text_mode(text_mode),
    .vblank_rise(vbl_rise), .cmp(cmp_val), .fire(line_fire)
  );

  always_comb begin
    set_ev           = '0;
    set_ev[SRC_VBL]  = vbl_rise;
    set_ev[SRC_LINE] = line_fire;
  end

  sirq_pend_bank #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set(set_ev), .clr(clr_ev), .pend(pend)
  );

  sirq_regbus #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .pend(pend),
    .hblank(hblank), .vblank(vblank), .clr(clr_ev), .en(en_bits),
    .cmp(cmp_val)
  );

  assign irq = |(pend & en_bits);
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       ack,
  input logic       irq,
  input logic       vbl_rise,
  input logic       line_fire,
  input logic [1:0] pend,
  input logic [1:0] en_bits
);
  logic fired_chk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired_chk <= 1'b0;
    else if (line_fire) fired_chk <= 1'b1;
    else if (vbl_rise) fired_chk <= 1'b0;
  end

  p_vbl_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_rise |=> pend[0]);

  p_line_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_fire |=> pend[1]);

  p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_fire |-> !fired_chk);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bits == 2'b00) |-> !irq);

  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_ack_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> ack);
endmodule

bind scanline_irq_unit sirq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .irq(irq),
  .vbl_rise(vbl_rise), .line_fire(line_fire), .pend(pend), .en_bits(en_bits)
);

// File: tb/sim_scanline_irq_unit.sv
`timescale 1ns/1ps
module sim_scanline_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  line_next = '0;
  logic        hblank = 1'b0, vblank = 1'b0, hblank_start = 1'b0, text_mode = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        ack, irq;
  logic [15:0] rdata;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  scanline_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .line_next(line_next), .hblank(hblank),
    .vblank(vblank), .hblank_start(hblank_start), .text_mode(text_mode),
    .req(req), .we(we), .addr(addr), .wdata(wdata), .ack(ack),
    .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata; req = 0;
  endtask

  task automatic hs_pulse(input logic [9:0] ln);
    @(negedge clk); line_next = ln; hblank_start = 1; hblank = 1;
    @(negedge clk); hblank_start = 0; hblank = 0;
  endtask

  task automatic new_frame();
    @(negedge clk); vblank = 1;
    repeat (2) @(negedge clk);
    vblank = 0;
    bus_wr(2'd0, 16'h0003);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 ack after reset", {15'd0, ack}, 16'd0);
    check("R1 irq after reset", {15'd0, irq}, 16'd0);
    bus_rd(2'd0, d); check("R1 status", d, 16'h0000);
    bus_rd(2'd1, d); check("R1 enable", d, 16'h0000);
    bus_rd(2'd2, d); check("R1 compare", d, 16'h0000);
  endtask

  task automatic t_bus();
    logic [15:0] d;
    @(negedge clk); req = 1; we = 0; addr = 2'd1;
    @(negedge clk); check("R11 ack high cycle after req", {15'd0, ack}, 16'd1); req = 0;
    @(negedge clk); check("R11 ack drops after one cycle", {15'd0, ack}, 16'd0);
    bus_wr(2'd2, 16'hFFFF); bus_rd(2'd2, d); check("R10 compare width", d, 16'h03FF);
    bus_wr(2'd3, 16'hFFFF); bus_rd(2'd3, d); check("R10 reg3 reads zero", d, 16'h0000);
    bus_rd(2'd2, d); check("R10 reg3 write ignored", d, 16'h03FF);
    bus_wr(2'd1, 16'hFFFF); bus_rd(2'd1, d); check("R6 enable readback", d, 16'h0003);
    bus_wr(2'd1, 16'h0000);
  endtask

  task automatic t_vblank();
    logic [15:0] d;
    @(negedge clk); vblank = 1;
    repeat (2) @(negedge clk);
    bus_rd(2'd0, d); check("R2 R7 vbl pending and live", d, 16'h0021);
    bus_wr(2'd0, 16'h0001);
    bus_rd(2'd0, d); check("R2 R8 cleared while level held", d, 16'h0020);
    @(negedge clk); vblank = 0; hblank = 1;
    bus_rd(2'd0, d); check("R7 live hblank", d, 16'h0010);
    hblank = 0;
    @(negedge clk); vblank = 1;
    @(negedge clk); vblank = 0;
    check("R6 irq gated by enable", {15'd0, irq}, 16'd0);
    bus_wr(2'd1, 16'h0001);
    check("R6 irq with vbl enable", {15'd0, irq}, 16'd1);
    bus_wr(2'd0, 16'h0001);
    check("R6 irq falls after clear", {15'd0, irq}, 16'd0);
    bus_wr(2'd1, 16'h0000);
  endtask

  task automatic t_line_halved();
    logic [15:0] d;
    text_mode = 0;
    bus_wr(2'd2, 16'd100);
    new_frame();
    @(negedge clk); line_next = 10'd200;
    @(negedge clk);
    bus_rd(2'd0, d); check("R3 no pulse no set", d, 16'h0000);
    hs_pulse(10'd199);
    bus_rd(2'd0, d); check("R3 line 199 -> 99 no match", d, 16'h0000);
    hs_pulse(10'd200);
    bus_rd(2'd0, d); check("R3 line 200 -> 100 match", d, 16'h0002);
    bus_wr(2'd1, 16'h0002);
    check("R6 irq with line enable", {15'd0, irq}, 16'd1);
    bus_wr(2'd0, 16'h0002);
    bus_wr(2'd1, 16'h0000);
    hs_pulse(10'd201);
    bus_rd(2'd0, d); check("R5 second display line no refire", d, 16'h0000);
    new_frame();
    hs_pulse(10'd201);
    bus_rd(2'd0, d); check("R5 rearmed after vblank", d, 16'h0002);
    bus_wr(2'd0, 16'h0002);
  endtask

  task automatic t_line_text();
    logic [15:0] d;
    text_mode = 1;
    new_frame();
    hs_pulse(10'd200);
    bus_rd(2'd0, d); check("R4 text 200 no match", d, 16'h0000);
    hs_pulse(10'd100);
    bus_rd(2'd0, d); check("R4 text 100 match", d, 16'h0002);
    @(negedge clk); vblank = 1;
    @(negedge clk); vblank = 0;
    bus_wr(2'd0, 16'h0001);
    bus_rd(2'd0, d); check("R8 selective clear", d, 16'h0002);
    bus_wr(2'd0, 16'h0002);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    text_mode = 1;
    new_frame();
    @(negedge clk); req = 1; we = 1; addr = 2'd0; wdata = 16'h0002;
    line_next = 10'd100; hblank_start = 1;
    @(negedge clk); req = 0; we = 0; hblank_start = 0;
    bus_rd(2'd0, d); check("R9 line set beats clear", d, 16'h0002);
    bus_wr(2'd0, 16'h0002);
    @(negedge clk); req = 1; we = 1; addr = 2'd0; wdata = 16'h0001; vblank = 1;
    @(negedge clk); req = 0; we = 0;
    bus_rd(2'd0, d); check("R9 vbl set beats clear", d, 16'h0021);
    vblank = 0;
    bus_wr(2'd0, 16'h0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bus();
    t_vblank();
    t_line_halved();
    t_line_text();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule